// File: doc/BRIEF.md
# Serial Shift Register with Edge Counter

This block moves bytes in and out one bit at a time. An 8-bit data register shifts left, with the new bit taken from a dedicated serial input. A 4-bit counter steps on the same clock source, so software can preset it and learn from its wrap when a transfer is done. A parallel bus port loads and reads both the data register and the counter. The register has no receive buffer, so a later transfer overwrites data that has not been read.

Three clock sources can drive the register and the counter: an external serial clock pin, a timer-overflow pulse, or a software strobe. The pin passes through a synchronizer and its edges are detected in the system clock domain. The register shifts on a rising pin edge, and the counter steps on both edges, so in pin mode it counts edges rather than bits. The register MSB reaches the serial output through a hold stage. This stage freezes the output while the synchronized pin is high, so the output changes only on the falling edge, opposite the sampling edge. A wire-mode setting sends that output to either a dedicated data-out pin or the shared two-wire data pin.

Top module: `ser_shift_core`

## Requirements
- R1: While `rst_n` is low, `data_q` and `cnt_q` are 0, `ovf_flag` and `irq` are 0, and the pin selected by `wire_mode` carries 0 while the other pin is 1.
- R2: On each shift tick without a data write, `data_q` becomes `{data_q[6:0], din}`. `din` is the only serial input in both wire modes.
- R3: `clk_src` encoding: 00 off (neither register nor counter moves), 01 pin (shift on a rising pin edge, count on either edge), 10 timer (`tmr_ovf` high shifts and counts once per cycle), 11 software (`sw_strobe` high shifts and counts once per cycle). Strobes of a source that is not selected have no effect.
- R4: A count tick with `cnt_q` at 15 and no counter write wraps `cnt_q` to 0 and sets `ovf_flag`.
- R5: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. If a wrap happens in the same cycle as `ovf_clr`, the flag stays set.
- R6: `irq` is high exactly when `ovf_flag` and `irq_en` are both high.
- R7: `cnt_wr` loads `cnt_wdata` into the counter and takes priority over a count tick in the same cycle. That tick is dropped and sets no overflow.
- R8: `data_wr` loads `data_wdata` into the register and takes priority over a shift tick in the same cycle.
- R9: In pin mode the serial output holds its value while the synchronized pin is high and follows the register MSB while it is low. In the other modes it follows the MSB directly.
- R10: With `wire_mode` 0 the serial output drives `dout3` and `sda_o` is held at 1. With `wire_mode` 1 the output drives `sda_o` and `dout3` is held at 1.
- R11: A change on `sck_pin` that is set up before a system clock edge shows up in `cnt_q` and `data_q` after the third system clock edge, counting that edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_src | input | 2 | Clock source select |
| wire_mode | input | 1 | 0 selects three-wire output, 1 selects two-wire output |
| irq_en | input | 1 | Interrupt enable |
| data_wr | input | 1 | Bus write strobe for the data register |
| data_wdata | input | 8 | Bus write value for the data register |
| cnt_wr | input | 1 | Bus write strobe for the counter |
| cnt_wdata | input | 4 | Bus write value for the counter |
| ovf_clr | input | 1 | Clears the overflow flag |
| sck_pin | input | 1 | External serial clock pin |
| tmr_ovf | input | 1 | Timer-overflow pulse |
| sw_strobe | input | 1 | Software clock strobe |
| din | input | 1 | Serial data input |
| data_q | output | 8 | Data register contents |
| cnt_q | output | 4 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt |
| dout3 | output | 1 | Three-wire data output |
| sda_o | output | 1 | Two-wire data output value (1 = released) |

## Verification
A bus write and a clock tick can land in the same cycle. So can a counter wrap and an overflow clear. Directed steps raise `cnt_wr` together with a software strobe, including with the counter at 15. They raise `data_wr` together with a strobe, and they raise `ovf_clr` in the very cycle the counter wraps. A long random phase then mixes writes, clears, strobes and pin toggles freely. Every cycle the outputs are compared with a bench model that gives the write priority over the tick and the wrap priority over the clear.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_PIN = 2'b01,
    SRC_TMR = 2'b10,
    SRC_SW  = 2'b11
  } clk_src_e;
endpackage

// File: rtl/ssc_rst_sync.sv
module ssc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_chain
      if (i == 0) begin : g_first
        assign chain_d[i] = 1'b1;
      end else begin : g_rest
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core = chain_q[STAGES-1];
endmodule

// File: rtl/ssc_clk_sel.sv
module ssc_clk_sel
  import ssc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_src_e src,
  input  logic     pin,
  input  logic     tmr_pulse,
  input  logic     sw_pulse,
  output logic     shift_tick,
  output logic     count_tick,
  output logic     latch_open
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   prev_d;
  logic                   pin_lvl;
  logic                   pin_rise;
  logic                   pin_fall;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_in
        assign sync_d[i] = pin;
      end else begin : g_mid
        assign sync_d[i] = sync_q[i-1];
      end
    end
  endgenerate

  assign pin_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    prev_d = pin_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pin_rise = pin_lvl & ~prev_q;
  assign pin_fall = ~pin_lvl & prev_q;

  always_comb begin
    shift_tick = 1'b0;
    count_tick = 1'b0;
    latch_open = 1'b1;
    case (src)
      SRC_PIN: begin
        shift_tick = pin_rise;
        count_tick = pin_rise | pin_fall;
        latch_open = ~pin_lvl;
      end
      SRC_TMR: begin
        shift_tick = tmr_pulse;
        count_tick = tmr_pulse;
      end
      SRC_SW: begin
        shift_tick = sw_pulse;
        count_tick = sw_pulse;
      end
      default: begin
        shift_tick = 1'b0;
        count_tick = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ssc_shift_reg.sv
module ssc_shift_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [DW-1:0] load_val,
  input  logic          shift_tick,
  input  logic          ser_in,
  input  logic          latch_open,
  input  logic          wire_mode,
  output logic [DW-1:0] data_q,
  output logic          dout3,
  output logic          sda_o
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] data_d;
  logic          data_en;
  logic          hold_q;
  logic          hold_d;
  logic          ser_bit;

  always_comb begin
    data_en = load_en | shift_tick;
    if (load_en) data_d = load_val;
    else         data_d = {data_q[MSB-1:0], ser_in};
    hold_d = data_q[MSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (latch_open) begin
      hold_q <= hold_d;
    end
  end

  assign ser_bit = latch_open ? data_q[MSB] : hold_q;
  assign dout3   = wire_mode ? 1'b1 : ser_bit;
  assign sda_o   = wire_mode ? ser_bit : 1'b1;
endmodule

// File: rtl/ssc_edge_cnt.sv
module ssc_edge_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          tick,
  input  logic          ovf_clr,
  input  logic          irq_en,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_q,
  output logic          irq
);
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};
  localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          wrap;
  logic          ovf_d;

  always_comb begin
    cnt_en = wr_en | tick;
    cnt_d  = wr_en ? wr_val : (cnt_q + CNT_ONE);
    wrap   = tick & ~wr_en & (cnt_q == CNT_TOP);
    if (wrap)         ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
    else              ovf_d = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign irq = ovf_q & irq_en;
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core
  import ssc_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    clk_src,
  input  logic          wire_mode,
  input  logic          irq_en,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          ovf_clr,
  input  logic          sck_pin,
  input  logic          tmr_ovf,
  input  logic          sw_strobe,
  input  logic          din,
  output logic [DW-1:0] data_q,
  output logic [CW-1:0] cnt_q,
  output logic          ovf_flag,
  output logic          irq,
  output logic          dout3,
  output logic          sda_o
);
  logic rst_core;
  logic shift_tick;
  logic cnt_tick;
  logic latch_open;

  ssc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_core (rst_core)
  );

  ssc_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk        (clk),
    .rst_n      (rst_core),
    .src        (clk_src_e'(clk_src)),
    .pin        (sck_pin),
    .tmr_pulse  (tmr_ovf),
    .sw_pulse   (sw_strobe),
    .shift_tick (shift_tick),
    .count_tick (cnt_tick),
    .latch_open (latch_open)
  );

  ssc_shift_reg #(.DW(DW)) u_shf (
    .clk        (clk),
    .rst_n      (rst_core),
    .load_en    (data_wr),
    .load_val   (data_wdata),
    .shift_tick (shift_tick),
    .ser_in     (din),
    .latch_open (latch_open),
    .wire_mode  (wire_mode),
    .data_q     (data_q),
    .dout3      (dout3),
    .sda_o      (sda_o)
  );

  ssc_edge_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_core),
    .wr_en   (cnt_wr),
    .wr_val  (cnt_wdata),
    .tick    (cnt_tick),
    .ovf_clr (ovf_clr),
    .irq_en  (irq_en),
    .cnt_q   (cnt_q),
    .ovf_q   (ovf_flag),
    .irq     (irq)
  );
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_core,
  input logic [1:0]    clk_src,
  input logic          wire_mode,
  input logic          data_wr,
  input logic [DW-1:0] data_wdata,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt_wdata,
  input logic          ovf_clr,
  input logic          din,
  input logic          shift_tick,
  input logic          cnt_tick,
  input logic          latch_open,
  input logic [DW-1:0] data_q,
  input logic [CW-1:0] cnt_q,
  input logic          ovf_flag,
  input logic          dout3,
  input logic          sda_o
);
  a_r2_shift_left: assert property (@(posedge clk) disable iff (!rst_core)
    (shift_tick && !data_wr) |=>
      (data_q == {$past(data_q[DW-2:0]), $past(din)}));

  a_r3_off_idle: assert property (@(posedge clk) disable iff (!rst_core)
    (clk_src == 2'b00 && !cnt_wr && !data_wr) |=> ($stable(cnt_q) && $stable(data_q)));

  a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_core)
    (cnt_tick && !cnt_wr && cnt_q == {CW{1'b1}}) |=> (ovf_flag && cnt_q == '0));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_core)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r7_cnt_write_wins: assert property (@(posedge clk) disable iff (!rst_core)
    cnt_wr |=> (cnt_q == $past(cnt_wdata)));

  a_r8_data_write_wins: assert property (@(posedge clk) disable iff (!rst_core)
    data_wr |=> (data_q == $past(data_wdata)));

  a_r9_latch_holds: assert property (@(posedge clk) disable iff (!rst_core)
    (!latch_open && !$past(latch_open) && $stable(wire_mode)) |-> $stable({dout3, sda_o}));

  a_r10_three_wire_idle: assert property (@(posedge clk) disable iff (!rst_core)
    !wire_mode |-> sda_o);

  a_r10_two_wire_idle: assert property (@(posedge clk) disable iff (!rst_core)
    wire_mode |-> dout3);
endmodule

bind ser_shift_core ssc_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_core   (rst_core),
  .clk_src    (clk_src),
  .wire_mode  (wire_mode),
  .data_wr    (data_wr),
  .data_wdata (data_wdata),
  .cnt_wr     (cnt_wr),
  .cnt_wdata  (cnt_wdata),
  .ovf_clr    (ovf_clr),
  .din        (din),
  .shift_tick (shift_tick),
  .cnt_tick   (cnt_tick),
  .latch_open (latch_open),
  .data_q     (data_q),
  .cnt_q      (cnt_q),
  .ovf_flag   (ovf_flag),
  .dout3      (dout3),
  .sda_o      (sda_o)
);

// File: tb/ser_shift_core_test.sv
module ser_shift_core_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_src;
  logic       wire_mode, irq_en, data_wr, cnt_wr, ovf_clr;
  logic [7:0] data_wdata;
  logic [3:0] cnt_wdata;
  logic       sck_pin, tmr_ovf, sw_strobe, din;
  logic [7:0] data_q;
  logic [3:0] cnt_q;
  logic       ovf_flag, irq, dout3, sda_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_data;
  logic [3:0] m_cnt;
  logic       m_ovf, m_hold, p1, p2, p3;

  always #10 clk = ~clk;

  ser_shift_core uut (
    .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .wire_mode(wire_mode),
    .irq_en(irq_en), .data_wr(data_wr), .data_wdata(data_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
    .sck_pin(sck_pin), .tmr_ovf(tmr_ovf), .sw_strobe(sw_strobe), .din(din),
    .data_q(data_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .irq(irq),
    .dout3(dout3), .sda_o(sda_o)
  );

  function automatic logic [7:0] shl(input logic [7:0] d, input logic b);
    return {d[6:0], b};
  endfunction

  function automatic logic open_of(input logic [1:0] s, input logic lvl);
    return (s == 2'b01) ? ~lvl : 1'b1;
  endfunction

  function automatic logic [15:0] expect_vec();
    logic o;
    o = open_of(clk_src, p2) ? m_data[7] : m_hold;
    return {m_data, m_cnt, m_ovf, m_ovf & irq_en,
            wire_mode ? 1'b1 : o, wire_mode ? o : 1'b1};
  endfunction

  task automatic check_all(input string tag);
    logic [15:0] act, exp;
    act = {data_q, cnt_q, ovf_flag, irq, dout3, sda_o};
    exp = expect_vec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (data,cnt,ovf,irq,dout3,sda)", tag, act, exp);
    end
  endtask

  task automatic idle();
    data_wr = 0; cnt_wr = 0; ovf_clr = 0; tmr_ovf = 0; sw_strobe = 0;
    data_wdata = '0; cnt_wdata = '0;
  endtask

  task automatic model_edge();
    logic rise, fall, sh, ct, op;
    rise = p2 & ~p3;
    fall = ~p2 & p3;
    case (clk_src)
      2'b01:   begin sh = rise;      ct = rise | fall; end
      2'b10:   begin sh = tmr_ovf;   ct = tmr_ovf;     end
      2'b11:   begin sh = sw_strobe; ct = sw_strobe;   end
      default: begin sh = 0;         ct = 0;           end
    endcase
    op = open_of(clk_src, p2);
    if (op) m_hold = m_data[7];
    if (data_wr)  m_data = data_wdata;
    else if (sh)  m_data = shl(m_data, din);
    if (ct && !cnt_wr && m_cnt == 4'hF) m_ovf = 1'b1;
    else if (ovf_clr)                   m_ovf = 1'b0;
    if (cnt_wr)   m_cnt = cnt_wdata;
    else if (ct)  m_cnt = m_cnt + 4'd1;
    p3 = p2; p2 = p1; p1 = sck_pin;
  endtask

  // inputs already set at a negedge; run one clock and check at the next negedge
  task automatic cyc(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic sw_shift(input logic b, input string tag);
    idle(); sw_strobe = 1; din = b; cyc(tag);
    idle();
  endtask

  initial begin
    #(100000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pat;
    int ok;
    ok = $urandom(1234);
    rst_n = 0; clk_src = 2'b00; wire_mode = 0; irq_en = 1; sck_pin = 0; din = 0;
    idle();
    m_data = 0; m_cnt = 0; m_ovf = 0; m_hold = 0; p1 = 0; p2 = 0; p3 = 0;
    repeat (3) @(negedge clk);
    check_all("R1 three-wire");
    wire_mode = 1; #1; check_all("R1 two-wire");
    wire_mode = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) cyc("R1 release");

    // R2: software strobe shifts din in MSB-first order
    clk_src = 2'b11;
    pat = 8'hA5;
    for (int i = 7; i >= 0; i--) sw_shift(pat[i], "R2");
    checks++;
    if (data_q !== 8'hA5) begin errors++; $display("FAIL R2 act=%h exp=a5", data_q); end
    wire_mode = 1;
    sw_shift(1'b1, "R2 two-wire din"); sw_shift(1'b0, "R10 two-wire route");
    wire_mode = 0; cyc("R10 three-wire route");

    // R4, R6: wrap from 15
    irq_en = 0;
    idle(); cnt_wr = 1; cnt_wdata = 4'd14; cyc("R7 load");
    sw_shift(1'b0, "R4 step"); sw_shift(1'b1, "R4 wrap");
    cyc("R6 masked");
    irq_en = 1; cyc("R6 irq");
    // R5: sticky, clear, wrap beats clear
    repeat (3) cyc("R5 sticky");
    idle(); ovf_clr = 1; cyc("R5 clear"); idle();
    cnt_wr = 1; cnt_wdata = 4'hF; cyc("R7 load 15");
    idle(); sw_strobe = 1; ovf_clr = 1; cyc("R5 wrap beats clear");
    idle(); ovf_clr = 1; cyc("R5 clear2"); idle();

    // R7: write beats tick, no overflow from 15
    cnt_wr = 1; cnt_wdata = 4'hF; cyc("R7");
    cnt_wr = 1; cnt_wdata = 4'd3; sw_strobe = 1; cyc("R7 write beats tick");
    idle(); cyc("R7 no overflow");
    // R8: data write beats shift
    data_wr = 1; data_wdata = 8'h3C; sw_strobe = 1; din = 1; cyc("R8");
    idle();

    // R3: off mode and unselected strobes
    clk_src = 2'b00;
    for (int i = 0; i < 12; i++) begin
      tmr_ovf = 1; sw_strobe = 1; sck_pin = i[1]; din = i[0]; cyc("R3 off");
    end
    idle(); sck_pin = 0; repeat (4) cyc("R3 settle");
    clk_src = 2'b10;
    for (int i = 0; i < 6; i++) begin
      tmr_ovf = i[0]; sw_strobe = ~i[0]; din = i[1]; cyc("R3 timer");
    end
    idle();

    // R9, R11: pin clock, slow levels
    clk_src = 2'b01; cyc("R11 idle");
    for (int i = 0; i < 16; i++) begin
      din = i[1] ^ i[2];
      sck_pin = ~sck_pin;
      for (int k = 0; k < 5; k++) cyc(k == 2 ? "R11 latency" : "R9 latch");
    end
    wire_mode = 1;
    for (int i = 0; i < 8; i++) begin
      din = i[0]; sck_pin = ~sck_pin;
      for (int k = 0; k < 4; k++) cyc("R9 two-wire");
    end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 32) == 0) clk_src = 2'($urandom);
      if (($urandom % 64) == 0) wire_mode = ~wire_mode;
      if (($urandom % 64) == 0) irq_en = ~irq_en;
      data_wr    = (($urandom % 16) == 0);
      data_wdata = 8'($urandom);
      cnt_wr     = (($urandom % 16) == 0);
      cnt_wdata  = 4'($urandom);
      ovf_clr    = (($urandom % 8) == 0);
      tmr_ovf    = 1'($urandom);
      sw_strobe  = 1'($urandom);
      din        = 1'($urandom);
      if (($urandom % 3) == 0) sck_pin = ~sck_pin;
      cyc("R3 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule